// File: doc/BRIEF.md
# Prioritised Restart Interrupt Controller

This block holds the interrupt state of a small 8-bit processor core. It takes one non-maskable request, three maskable restart requests of fixed rank (high, mid, low), and one general request. The general request's service routine is chosen by an opcode that external hardware supplies. The block keeps a global enable bit and one mask bit for each restart request. A mask-write operation updates the mask bits. A mask-read port always shows the masks, the global enable and the three restart pending bits.

The core raises `boundary_i` at an instruction boundary. In that cycle the block picks the highest-ranked serviceable request. On the next clock it pulses `ack_o` and presents the 16-bit vector address. For the general request it raises `ext_o` instead, because the vector then comes from the supplied opcode. Accepting any request clears the global enable.

Top module: `vec_int_ctrl`

## Requirements
- R1: After reset all three restart masks are set, the global enable is clear, no latch is pending and `ack_o` is low, so `mask_rdata_o` reads 8'h07.
- R2: Ranking from highest is non-maskable, high, mid, low, general. The vectors are 16'h0024, 16'h003C, 16'h0034 and 16'h002C for the first four. The general request gives `ext_o`=1 with `vec_o`=0.
- R3: A restart request whose mask bit is 1 is never accepted. While the global enable is 0, no restart request and no general request is accepted.
- R4: The high request is latched on a rising edge of `irq_hi_i` and stays pending after the input falls. A level held high does not latch again after the latch clears.
- R5: The mid and low requests are level-sensitive. Their pending bits follow the inputs with no delay, and a request that is dropped before the boundary is not accepted.
- R6: A mask write with `mask_wdata_i[3]`=1 loads bits 2:0 as the masks for low/mid/high. With bit 3 at 0 the masks are unchanged. Bit 4 = 1 clears the high latch.
- R7: Accepting any request clears the global enable and clears that request's own latch (high or non-maskable). `ei_i` sets the enable and `di_i` clears it.
- R8: `ack_o` is a one-cycle pulse in the cycle after a `boundary_i` cycle that had a serviceable request. Without `boundary_i` nothing is accepted.
- R9: The non-maskable request is latched on a rising edge of `nmi_i`. It is accepted whatever the global enable and the masks are.
- R10: `mask_rdata_o` bits 2:0 are the masks (low, mid, high). Bit 3 is the global enable, bits 6:4 are pending low, mid, high, and bit 7 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| nmi_i | input | 1 | Non-maskable request, rising-edge latched |
| irq_hi_i | input | 1 | High restart request, rising-edge latched |
| irq_mid_i | input | 1 | Mid restart request, level |
| irq_lo_i | input | 1 | Low restart request, level |
| ext_req_i | input | 1 | General request served by an external opcode |
| ei_i | input | 1 | Set global enable |
| di_i | input | 1 | Clear global enable |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 8 | Mask write data |
| mask_rdata_o | output | 8 | Masks, enable and pending bits |
| boundary_i | input | 1 | Instruction boundary, selection cycle |
| ack_o | output | 1 | Request accepted (one cycle) |
| vec_o | output | 16 | Vector address of the accepted request |
| ext_o | output | 1 | Accepted request is the general request |

## Verification
The low and mid pending bits show up on `mask_rdata_o` in the same cycle as their inputs. The bench reads them one time unit after changing the input. Edge latches, mask writes and enable changes take effect at the next rising clock edge. The bench therefore drives each strobe for one full cycle from a falling edge and reads the result at the following falling edge. `ack_o`, `vec_o` and `ext_o` are registered one edge after the `boundary_i` cycle, so each acceptance check samples at the falling edge that ends that boundary cycle.

// File: rtl/vec_int_ctrl.sv
module vec_int_ctrl #(
  parameter int          VEC_W   = 16,
  parameter logic [15:0] VEC_NMI = 16'h0024,
  parameter logic [15:0] VEC_HI  = 16'h003C,
  parameter logic [15:0] VEC_MID = 16'h0034,
  parameter logic [15:0] VEC_LO  = 16'h002C
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nmi_i,
  input  logic             irq_hi_i,
  input  logic             irq_mid_i,
  input  logic             irq_lo_i,
  input  logic             ext_req_i,
  input  logic             ei_i,
  input  logic             di_i,
  input  logic             mask_we_i,
  input  logic [7:0]       mask_wdata_i,
  output logic [7:0]       mask_rdata_o,
  input  logic             boundary_i,
  output logic             ack_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             ext_o
);

  logic [2:0] msk;
  logic       ie, hi_lat, nmi_lat, hi_q, nmi_q;

  wire       hi_edge  = irq_hi_i & ~hi_q;
  wire       nmi_edge = nmi_i & ~nmi_q;
  wire [2:0] pend     = {hi_lat, irq_mid_i, irq_lo_i};
  wire [2:0] live     = pend & ~msk & {3{ie}};
  wire       gen_ok   = ie & ext_req_i;
  wire       any_req  = nmi_lat | (|live) | gen_ok;
  wire       take     = boundary_i & any_req;
  wire       take_nmi = take & nmi_lat;
  wire       take_hi  = take & ~nmi_lat & live[2];
  wire       clr_hi   = mask_we_i & mask_wdata_i[4];

  logic [VEC_W-1:0] sel_vec;
  logic             sel_ext;

  always_comb begin
    sel_ext = 1'b0;
    if (nmi_lat)      sel_vec = VEC_W'(VEC_NMI);
    else if (live[2]) sel_vec = VEC_W'(VEC_HI);
    else if (live[1]) sel_vec = VEC_W'(VEC_MID);
    else if (live[0]) sel_vec = VEC_W'(VEC_LO);
    else begin
      sel_vec = '0;
      sel_ext = 1'b1;
    end
  end

  assign mask_rdata_o = {1'b0, pend, ie, msk};

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      msk     <= 3'b111;
      ie      <= 1'b0;
      hi_lat  <= 1'b0;
      nmi_lat <= 1'b0;
      hi_q    <= 1'b0;
      nmi_q   <= 1'b0;
      ack_o   <= 1'b0;
      vec_o   <= '0;
      ext_o   <= 1'b0;
    end else begin
      hi_q    <= irq_hi_i;
      nmi_q   <= nmi_i;
      ack_o   <= take;
      hi_lat  <= (hi_lat & ~clr_hi & ~take_hi) | hi_edge;
      nmi_lat <= (nmi_lat & ~take_nmi) | nmi_edge;
      if (mask_we_i && mask_wdata_i[3]) msk <= mask_wdata_i[2:0];
      if (ei_i) ie <= 1'b1;
      if (di_i) ie <= 1'b0;
      if (take) begin
        ie    <= 1'b0;
        vec_o <= sel_vec;
        ext_o <= sel_ext;
      end
    end
  end

endmodule

module vec_int_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        boundary_i,
  input logic        mask_we_i,
  input logic [7:0]  mask_wdata_i,
  input logic [7:0]  mask_rdata_o,
  input logic        ack_o,
  input logic [15:0] vec_o,
  input logic        ext_o
);

  AST_ACK_NEEDS_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(boundary_i)); // R8

  AST_ACCEPT_DROPS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !mask_rdata_o[3]); // R7

  AST_HI_NOT_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && vec_o == 16'h003C) |-> ($past(!mask_rdata_o[2]) && $past(mask_rdata_o[3]))); // R3

  AST_EXT_NEEDS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && ext_o) |-> $past(mask_rdata_o[3])); // R3

  AST_HI_LATCH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mask_rdata_o[6]) && !$past(boundary_i) && !$past(mask_we_i && mask_wdata_i[4]))
      |-> mask_rdata_o[6]); // R4

  AST_BIT7_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_rdata_o[7]); // R10

endmodule

bind vec_int_ctrl vec_int_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .boundary_i(boundary_i),
  .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i),
  .mask_rdata_o(mask_rdata_o), .ack_o(ack_o), .vec_o(vec_o), .ext_o(ext_o)
);

// File: tb/tb_vec_int_ctrl.sv
`timescale 1ns/1ps
module tb_vec_int_ctrl;
  logic clk = 0, rst_n = 0;
  logic nmi = 0, ihi = 0, imid = 0, ilo = 0, ext_req = 0;
  logic ei = 0, di = 0, mwe = 0, bnd = 0;
  logic [7:0] mwd = 0;
  logic [7:0] rd;
  logic ack, ext;
  logic [15:0] vec;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vec_int_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .nmi_i(nmi), .irq_hi_i(ihi), .irq_mid_i(imid),
    .irq_lo_i(ilo), .ext_req_i(ext_req), .ei_i(ei), .di_i(di), .mask_we_i(mwe),
    .mask_wdata_i(mwd), .mask_rdata_o(rd), .boundary_i(bnd), .ack_o(ack),
    .vec_o(vec), .ext_o(ext));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_ei();  @(negedge clk) ei = 1; @(negedge clk) ei = 0; endtask
  task automatic do_di();  @(negedge clk) di = 1; @(negedge clk) di = 0; endtask
  task automatic wmask(input logic [7:0] d);
    @(negedge clk) begin mwe = 1; mwd = d; end
    @(negedge clk) mwe = 0;
  endtask
  task automatic pulse_hi();  @(negedge clk) ihi = 1; @(negedge clk) ihi = 0; endtask
  task automatic pulse_nmi(); @(negedge clk) nmi = 1; @(negedge clk) nmi = 0; endtask

  task automatic take(input string tag, input logic e_ack, input logic [15:0] e_vec, input logic e_ext);
    @(negedge clk) bnd = 1;
    @(negedge clk) bnd = 0;
    #1;
    chk({tag, " ack"}, 16'(ack), 16'(e_ack));
    if (e_ack) begin
      chk({tag, " vec"}, vec, e_vec);
      chk({tag, " ext"}, 16'(ext), 16'(e_ext));
    end
  endtask

  task automatic t_reset();
    #1 chk("R1 reset read", 16'(rd), 16'h07);
    chk("R1 reset ack", 16'(ack), 0);
  endtask

  task automatic t_mask_write();
    wmask(8'h08); #1 chk("R6 load masks", 16'(rd), 16'h00);
    wmask(8'h07); #1 chk("R6 no update bit3=0", 16'(rd), 16'h00);
    wmask(8'h0D); #1 chk("R10 mask field", 16'(rd), 16'h05);
    wmask(8'h08);
  endtask

  task automatic t_enable_gate();
    @(negedge clk) ilo = 1;
    #1 chk("R5 low pending follows level", 16'(rd), 16'h10);
    take("R3 disabled blocks low", 0, 0, 0);
    do_ei(); #1 chk("R10 enable bit", 16'(rd), 16'h18);
    take("R2 low vector", 1, 16'h002C, 0);
    #1 chk("R7 accept clears enable", 16'(rd[3]), 0);
    @(negedge clk) ilo = 0;
  endtask

  task automatic t_priority();
    @(negedge clk) begin ilo = 1; imid = 1; ext_req = 1; end
    do_ei();
    take("R2 mid over low", 1, 16'h0034, 0);
    wmask(8'h0A); do_ei();
    take("R3 masked mid skipped", 1, 16'h002C, 0);
    @(negedge clk) imid = 0;
    take("R3 enable off after accept", 0, 0, 0);
    wmask(8'h08);
    @(negedge clk) begin ilo = 0; end
    do_ei();
    take("R2 general request", 1, 16'h0000, 1);
    @(negedge clk) ext_req = 0;
  endtask

  task automatic t_level_drop();
    do_ei();
    @(negedge clk) imid = 1;
    @(negedge clk) imid = 0;
    take("R5 dropped level not taken", 0, 0, 0);
    @(negedge clk) ilo = 1;
    repeat (4) @(negedge clk);
    #1 chk("R8 no accept without boundary", 16'(ack), 0);
    @(negedge clk) ilo = 0;
    do_di();
  endtask

  task automatic t_hi_edge();
    pulse_hi(); #1 chk("R4 high latched after edge", 16'(rd[6]), 1);
    repeat (3) @(negedge clk);
    #1 chk("R4 high latch holds", 16'(rd[6]), 1);
    @(negedge clk) ilo = 1;
    do_ei();
    take("R2 high over low", 1, 16'h003C, 0);
    #1 chk("R7 high latch cleared by accept", 16'(rd[6]), 0);
    do_ei();
    take("R2 low after high", 1, 16'h002C, 0);
    @(negedge clk) ilo = 0;
  endtask

  task automatic t_hi_masked();
    wmask(8'h0C);
    pulse_hi(); #1 chk("R4 latch while masked", 16'(rd), 16'h44);
    do_ei();
    take("R3 masked high not taken", 0, 0, 0);
    wmask(8'h18); #1 chk("R6 bit4 clears high latch", 16'(rd), 16'h08);
    take("R6 cleared latch not taken", 0, 0, 0);
    do_di();
  endtask

  task automatic t_hi_held();
    @(negedge clk) ihi = 1;
    do_ei();
    take("R4 held high first accept", 1, 16'h003C, 0);
    do_ei();
    take("R4 held level no relatch", 0, 0, 0);
    #1 chk("R4 pending stays clear", 16'(rd[6]), 0);
    @(negedge clk) ihi = 0;
    do_di();
  endtask

  task automatic t_nmi();
    wmask(8'h0F);
    pulse_hi(); pulse_nmi();
    take("R9 nmi ignores enable and masks", 1, 16'h0024, 0);
    take("R9 nmi latch consumed", 0, 0, 0);
    wmask(8'h08);
    do_ei();
    pulse_nmi();
    take("R2 nmi over high", 1, 16'h0024, 0);
    #1 chk("R7 high still pending", 16'(rd[6]), 1);
    do_ei();
    take("R2 high after nmi", 1, 16'h003C, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk) rst_n = 1;
    t_mask_write();
    t_enable_gate();
    t_priority();
    t_level_drop();
    t_hi_edge();
    t_hi_masked();
    t_hi_held();
    t_nmi();
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule